// File: doc/BRIEF.md
# Constant Multiplier by Minus Five

This block takes a signed two's-complement operand and returns that operand multiplied by the fixed constant minus five. It has no multiplier array. The constant is recoded into two radix-4 Booth digits, both equal to minus one, with weights four and one. The product is therefore the negation of the operand shifted left by two plus the operand itself.

Both partial terms are sign-extended to the output width before they are added. One ripple adder forms the sum. The negation is then done by inverting that sum and adding a carry-in of one in a second adder stage. There is no adder for a general operand and no array of partial products.

The block is purely combinational. It is meant to sit inside a datapath that needs a fixed scaling by minus five. The output is three bits wider than the input, so every product can be represented and no saturation is needed.

Top module: `mul_neg5`

## Requirements
- R1: For every input value, `prod_o` read as a 9-bit two's-complement number equals minus five times `a_i` read as a 6-bit two's-complement number (bit 5 is the sign).
- R2: The most negative input, -32 (6'b100000), gives +160 (9'h0A0).
- R3: The most positive input, +31 (6'b011111), gives -155 (9'h165).
- R4: An input of zero gives an all-zero output.
- R5: Output bit 8 (the sign) is 1 exactly when the input is positive and nonzero. For a negative or zero input it is 0.
- R6: Output bit 0 always equals input bit 0, because multiplying by an odd constant keeps parity.
- R7: An input of -1 (6'b111111) gives +5 (9'h005).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 6 | Signed two's-complement operand |
| prod_o | output | 9 | Signed two's-complement product, minus five times the operand |

## Verification
Every one of the 64 operand codes is applied in turn, so the sweep covers both signs, zero, and the two extremes of the range. The extremes show whether the sign extension of the shifted term and the final carry are right, because a missing guard bit makes +160 wrap or -155 lose its sign. The codes zero and minus one separate errors in the inversion and carry-in of the negation from errors in the sum, since their expected outputs are all-zero and a small positive value. A seeded random run then repeats operands in arbitrary order, which would expose any dependence on the previous input.

// File: rtl/mul_neg5_pkg.sv
package mul_neg5_pkg;

    // default operand width in bits
    localparam int unsigned IN_W_DEF    = 6;
    // guard bits needed so |5*A| never overflows the product
    localparam int unsigned GUARD_W     = 3;
    // left shift for the Booth digit at weight four
    localparam int unsigned BOOTH_SHIFT = 2;

    function automatic int unsigned prod_width(input int unsigned in_w);
        return in_w + GUARD_W;
    endfunction

endpackage

// File: rtl/neg5_booth_terms.sv
module neg5_booth_terms #(
    parameter int unsigned IN_W  = 6,
    parameter int unsigned OUT_W = 9,
    parameter int unsigned SHIFT = 2
) (
    input  logic [IN_W-1:0]  a_i,
    output logic [OUT_W-1:0] term_w1_o,
    output logic [OUT_W-1:0] term_w4_o
);

    localparam int unsigned EXT_W = OUT_W - IN_W;

    // both Booth digits are -1; magnitudes are formed here and negated later
    assign term_w1_o = {{EXT_W{a_i[IN_W-1]}}, a_i};
    assign term_w4_o = term_w1_o << SHIFT;

endmodule

// File: rtl/neg5_rca.sv
module neg5_rca #(
    parameter int unsigned W = 9
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o
);

    logic [W-1:0] carry;

    assign carry[0] = cin_i;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum_o[i] = x_i[i] ^ y_i[i] ^ carry[i];
        if (i < W - 1) begin : g_carry
            assign carry[i+1] = (x_i[i] & y_i[i]) | (carry[i] & (x_i[i] ^ y_i[i]));
        end
    end

endmodule

// File: rtl/mul_neg5.sv
module mul_neg5
    import mul_neg5_pkg::*;
#(
    parameter int unsigned IN_W  = IN_W_DEF,
    localparam int unsigned OUT_W = prod_width(IN_W)
) (
    input  logic [IN_W-1:0]  a_i,
    output logic [OUT_W-1:0] prod_o
);

    typedef struct packed {
        logic [OUT_W-1:0] mag;
        logic [OUT_W-1:0] inv;
    } stage_t;

    logic [OUT_W-1:0] term_w1;
    logic [OUT_W-1:0] term_w4;
    logic [OUT_W-1:0] sum_mag;
    logic [OUT_W-1:0] neg_out;
    stage_t           stage_d;

    neg5_booth_terms #(
        .IN_W  (IN_W),
        .OUT_W (OUT_W),
        .SHIFT (BOOTH_SHIFT)
    ) terms_u (
        .a_i       (a_i),
        .term_w1_o (term_w1),
        .term_w4_o (term_w4)
    );

    // 4A + A
    neg5_rca #(.W(OUT_W)) sum_u (
        .x_i   (term_w4),
        .y_i   (term_w1),
        .cin_i (1'b0),
        .sum_o (sum_mag)
    );

    always_comb begin
        stage_d     = '0;
        stage_d.mag = sum_mag;
        stage_d.inv = ~sum_mag;
    end

    // negation: inverted sum plus carry-in of one
    neg5_rca #(.W(OUT_W)) neg_u (
        .x_i   (stage_d.inv),
        .y_i   ({OUT_W{1'b0}}),
        .cin_i (1'b1),
        .sum_o (neg_out)
    );

    assign prod_o = neg_out;

endmodule

// File: rtl/mul_neg5_chk.sv
module mul_neg5_chk #(
    parameter int unsigned IN_W  = 6,
    parameter int unsigned OUT_W = 9
) (
    input logic [IN_W-1:0]  a_i,
    input logic [OUT_W-1:0] prod_o
);

    localparam int MIN_IN = -(2 ** (IN_W - 1));
    localparam int MAX_IN = (2 ** (IN_W - 1)) - 1;

    int aval;
    int pval;

    always_comb begin
        aval = int'($signed(a_i));
        pval = int'($signed(prod_o));

        p_product_r1: assert (pval == -5 * aval)
            else $error("R1 product %0d for operand %0d", pval, aval);

        if (aval == MIN_IN) begin
            p_min_in_r2: assert (pval == -5 * MIN_IN)
                else $error("R2 product %0d", pval);
        end

        if (aval == MAX_IN) begin
            p_max_in_r3: assert (pval == -5 * MAX_IN)
                else $error("R3 product %0d", pval);
        end

        if (aval == 0) begin
            p_zero_r4: assert (prod_o == '0)
                else $error("R4 product %0d", pval);
        end

        p_sign_r5: assert (prod_o[OUT_W-1] == (aval > 0))
            else $error("R5 sign wrong for operand %0d", aval);

        p_parity_r6: assert (prod_o[0] == a_i[0])
            else $error("R6 parity wrong for operand %0d", aval);

        if (aval == -1) begin
            p_minus_one_r7: assert (pval == 5)
                else $error("R7 product %0d", pval);
        end
    end

endmodule

bind mul_neg5 mul_neg5_chk #(
    .IN_W  (IN_W),
    .OUT_W (OUT_W)
) chk_i (
    .a_i    (a_i),
    .prod_o (prod_o)
);

// File: tb/mul_neg5_tb_top.sv
module mul_neg5_tb_top;

    localparam int IN_W   = 6;
    localparam int OUT_W  = 9;
    localparam int NRAND  = 300;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [IN_W-1:0]  a;
    logic [OUT_W-1:0] prod;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    mul_neg5 dut_i (
        .a_i    (a),
        .prod_o (prod)
    );

    function automatic logic [OUT_W-1:0] exp_prod(input logic [IN_W-1:0] v);
        int p;
        p = -5 * int'($signed(v));
        return p[OUT_W-1:0];
    endfunction

    task automatic check(input string req, input logic [OUT_W-1:0] act,
                         input logic [OUT_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: operand %0d actual %h expected %h",
                     req, $signed(a), act, exp);
        end
    endtask

    task automatic apply(input logic [IN_W-1:0] v);
        @(posedge clk);
        a = v;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        a = '0;
        void'($urandom(32'h5EED_0005));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: zero operand
        check("R4", prod, 9'h000);

        // R2: most negative operand
        apply(6'b100000);
        check("R2", prod, 9'h0A0);

        // R3: most positive operand
        apply(6'b011111);
        check("R3", prod, 9'h165);

        // R7: minus one
        apply(6'b111111);
        check("R7", prod, 9'h005);

        // R1, R5, R6: exhaustive sweep
        for (int v = 0; v < (1 << IN_W); v++) begin
            apply(v[IN_W-1:0]);
            check("R1", prod, exp_prod(a));
            check("R5", {8'b0, prod[OUT_W-1]},
                  {8'b0, ($signed(a) > 0)});
            check("R6", {8'b0, prod[0]}, {8'b0, a[0]});
        end

        // R1: random operand order
        for (int k = 0; k < NRAND; k++) begin
            apply(IN_W'($urandom));
            check("R1", prod, exp_prod(a));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule